// File: doc/BRIEF.md
# Camera Byte Formatter

This block sits at the end of an image pipeline. It turns each processed pixel into two bytes for an 8-bit camera port. A pixel arrives as three 8-bit channel values. These are either luma plus both chroma components (Y, Cb, Cr) or red, green and blue. A pixel can also arrive as one raw sensor sample of `RAW_W` bits. The block accepts one pixel through a valid/ready handshake and then sends its two bytes on consecutive cycles with a byte strobe. Pixels can therefore be streamed at one pixel every two clocks.

A set of configuration pins selects how the bytes are built:

- YCbCr 4:2:2 or one of four packed 16-bit RGB layouts.
- A byte-position swap.
- A channel swap.
- A 3-bit upward shift for driving low-depth displays.
- Averaging of chroma between neighbouring pixels.
- A raw bypass that takes priority over every other setting.

The configuration pins are sampled only on a frame-start strobe, so a frame never mixes formats. Frame-start and line-start strobes also reset the pixel parity that decides which chroma component goes with each pixel.

Top module: `cam_byte_formatter`

## Requirements
- R1: A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. `out_valid` is then high for exactly the two following cycles: the first byte in the first of these cycles, the second byte in the next. `in_ready` is low during the first of those cycles and high otherwise.
- R2: In YCbCr mode (`rgb_en`=0, bypass=0), pixels are numbered from 0 after each frame or line start. Each pixel sends its chroma byte first and then its luma (`in_c0`). The chroma is Cb (`in_c1`) on even-numbered pixels and Cr (`in_c2`) on odd-numbered pixels. With `swap_pos`=1 the luma is sent first.
- R3: In YCbCr mode with `swap_chan`=1, Cr goes with even-numbered pixels and Cb with odd-numbered pixels.
- R4: In RGB mode (`rgb_en`=1), the channels are R=`in_c0`, G=`in_c1`, B=`in_c2`. They form a 16-bit word W and W[15:8] is sent first. `rgb_fmt` selects the layout of W:
  - 00: {R[7:3],G[7:2],B[7:3]}
  - 01: {0,R[7:3],G[7:3],B[7:3]}
  - 10: {R[7:4],G[7:4],B[7:4],4'h0}
  - 11: {4'h0,R[7:4],G[7:4],B[7:4]}
- R5: In RGB mode, `swap_pos`=1 sends W[7:0] first. `swap_chan`=1 exchanges R and B before packing.
- R6: With `shift3`=1 in YCbCr or RGB mode, each channel value is shifted left by 3 modulo 256, with zeros entering at the bottom. In RGB mode this happens before packing. In YCbCr mode it applies to the chroma byte after averaging and to the luma byte.
- R7: With `chroma_avg`=1 in YCbCr mode, the chroma byte of a pixel is floor((c_p + c_(p-1))/2). Here c is the chroma component that pixel sends, taken from the current pixel and from the previous pixel of the same line. The first pixel after a frame or line start sends its own value.
- R8: With `raw_bypass`=1, the first byte is `in_raw`[RAW_W-1:RAW_W-8] and the second byte is `in_raw`[RAW_W-9:0] zero-extended. Mode, swap and shift settings have no effect.
- R9: Configuration pins are captured only in a cycle where `frame_start` is high. Changes made at any other time do not affect the output until the next frame start.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and the active configuration is all zeros (YCbCr, no swaps, no shift, no averaging, no bypass).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_raw_bypass | input | 1 | Send raw sample instead of processed pixel |
| cfg_rgb_en | input | 1 | 1 selects RGB output, 0 YCbCr |
| cfg_rgb_fmt | input | 2 | Packed RGB layout selector |
| cfg_swap_pos | input | 1 | Exchange byte order within a pixel |
| cfg_swap_chan | input | 1 | Exchange Cb/Cr or R/B |
| cfg_shift3 | input | 1 | Shift channel values up 3 bits |
| cfg_chroma_avg | input | 1 | Average chroma with previous pixel |
| frame_start | input | 1 | Frame-start strobe; loads configuration, resets parity |
| line_start | input | 1 | Line-start strobe; resets parity |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block can accept a pixel |
| in_c0 | input | 8 | Y or R |
| in_c1 | input | 8 | Cb or G |
| in_c2 | input | 8 | Cr or B |
| in_raw | input | RAW_W | Raw sensor sample |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Output byte strobe |

## Verification
The assertions assume that a frame or line strobe never arrives in the same cycle as `in_valid`. One of them flags a violation, because a restart and an acceptance in the same cycle would leave pixel parity ambiguous. The byte-layout properties sample the active configuration during the two output cycles. They therefore also assume that a frame start does not land between the acceptance of a pixel and its first byte. The bench drives each pixel for exactly one cycle, followed by one idle cycle. It issues strobes only from that idle slot, with `in_valid` low, so every stimulus stays inside these assumptions.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

   typedef enum logic [1:0] {
      RGB_565        = 2'b00,
      RGB_555        = 2'b01,
      RGB_444_LO_PAD = 2'b10,
      RGB_444_HI_PAD = 2'b11
   } rgb_fmt_e;

   typedef struct packed {
      logic     raw_bypass;
      logic     rgb_en;
      rgb_fmt_e rgb_fmt;
      logic     swap_pos;
      logic     swap_chan;
      logic     shift3;
      logic     chroma_avg;
   } cbf_cfg_t;

   function automatic logic [7:0] shl3(input logic [7:0] v);
      return {v[4:0], 3'b000};
   endfunction

   function automatic logic [15:0] pack_rgb(input rgb_fmt_e f,
                                            input logic [7:0] r,
                                            input logic [7:0] g,
                                            input logic [7:0] b);
      logic [15:0] w;
      case (f)
         RGB_565:        w = {r[7:3], g[7:2], b[7:3]};
         RGB_555:        w = {1'b0, r[7:3], g[7:3], b[7:3]};
         RGB_444_LO_PAD: w = {r[7:4], g[7:4], b[7:4], 4'h0};
         default:        w = {4'h0, r[7:4], g[7:4], b[7:4]};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/cbf_cfg_hold.sv
module cbf_cfg_hold
   import cbf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  cbf_cfg_t cfg_d,
   output cbf_cfg_t cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (load) cfg_q <= cfg_d;
   end

endmodule

// File: rtl/cbf_chroma_track.sv
module cbf_chroma_track #(
   parameter int CH_W      = 8,
   parameter int AVG_ROUND = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            accept,
   input  logic            swap_chan,
   input  logic            avg_en,
   input  logic [CH_W-1:0] cb,
   input  logic [CH_W-1:0] cr,
   output logic [CH_W-1:0] chroma
);

   localparam int SUM_W = CH_W + 1;

   logic            odd_q;
   logic            prev_ok_q;
   logic [CH_W-1:0] prev_cb_q;
   logic [CH_W-1:0] prev_cr_q;
   logic            use_cr;
   logic [CH_W-1:0] cur_c;
   logic [CH_W-1:0] old_c;
   logic [SUM_W-1:0] pair_sum;
   logic [CH_W-1:0] mean_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odd_q     <= 1'b0;
         prev_ok_q <= 1'b0;
         prev_cb_q <= '0;
         prev_cr_q <= '0;
      end else if (restart) begin
         odd_q     <= 1'b0;
         prev_ok_q <= 1'b0;
      end else if (accept) begin
         odd_q     <= ~odd_q;
         prev_ok_q <= 1'b1;
         prev_cb_q <= cb;
         prev_cr_q <= cr;
      end
   end

   always_comb begin
      use_cr   = odd_q ^ swap_chan;
      cur_c    = use_cr ? cr : cb;
      old_c    = use_cr ? prev_cr_q : prev_cb_q;
      pair_sum = {1'b0, cur_c} + {1'b0, old_c};
   end

   generate
      if (AVG_ROUND != 0) begin : g_round
         logic [SUM_W:0] sum_r;
         assign sum_r  = {1'b0, pair_sum} + {{SUM_W{1'b0}}, 1'b1};
         assign mean_c = sum_r[SUM_W-1:1];
      end else begin : g_floor
         assign mean_c = pair_sum[SUM_W-1:1];
      end
   endgenerate

   assign chroma = (avg_en && prev_ok_q) ? mean_c : cur_c;

endmodule

// File: rtl/cbf_word_build.sv
module cbf_word_build
   import cbf_pkg::*;
#(
   parameter int RAW_W = 10
) (
   input  cbf_cfg_t         cfg,
   input  logic [7:0]       c0,
   input  logic [7:0]       c1,
   input  logic [7:0]       c2,
   input  logic [7:0]       chroma,
   input  logic [RAW_W-1:0] raw,
   output logic [7:0]       byte0,
   output logic [7:0]       byte1
);

   localparam int LO_W = RAW_W - 8;

   logic [7:0]  r_v, g_v, b_v, y_v, c_v;
   logic [15:0] word;
   logic [15:0] word_s;
   logic [7:0]  raw_hi;
   logic [7:0]  raw_lo;

   assign raw_hi = raw[RAW_W-1 -: 8];

   generate
      if (LO_W == 8) begin : g_lo_full
         assign raw_lo = raw[7:0];
      end else begin : g_lo_pad
         assign raw_lo = {{(8-LO_W){1'b0}}, raw[LO_W-1:0]};
      end
   endgenerate

   always_comb begin
      r_v = cfg.swap_chan ? c2 : c0;
      b_v = cfg.swap_chan ? c0 : c2;
      g_v = c1;
      y_v = c0;
      c_v = chroma;
      if (cfg.shift3) begin
         r_v = shl3(r_v);
         g_v = shl3(g_v);
         b_v = shl3(b_v);
         y_v = shl3(y_v);
         c_v = shl3(c_v);
      end
      word   = cfg.rgb_en ? pack_rgb(cfg.rgb_fmt, r_v, g_v, b_v) : {c_v, y_v};
      word_s = cfg.swap_pos ? {word[7:0], word[15:8]} : word;
      if (cfg.raw_bypass) begin
         byte0 = raw_hi;
         byte1 = raw_lo;
      end else begin
         byte0 = word_s[15:8];
         byte1 = word_s[7:0];
      end
   end

endmodule

// File: rtl/cbf_byte_ser.sv
module cbf_byte_ser (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] b0,
   input  logic [7:0] b1,
   output logic [7:0] out_byte,
   output logic       out_valid,
   output logic       busy
);

   logic [7:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte  <= '0;
         out_valid <= 1'b0;
         busy      <= 1'b0;
         hold_q    <= '0;
      end else if (accept) begin
         out_byte  <= b0;
         hold_q    <= b1;
         out_valid <= 1'b1;
         busy      <= 1'b1;
      end else if (busy) begin
         out_byte  <= hold_q;
         out_valid <= 1'b1;
         busy      <= 1'b0;
      end else begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/cam_byte_formatter.sv
module cam_byte_formatter
   import cbf_pkg::*;
#(
   parameter int CH_W      = 8,
   parameter int RAW_W     = 10,
   parameter int AVG_ROUND = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_raw_bypass,
   input  logic             cfg_rgb_en,
   input  logic [1:0]       cfg_rgb_fmt,
   input  logic             cfg_swap_pos,
   input  logic             cfg_swap_chan,
   input  logic             cfg_shift3,
   input  logic             cfg_chroma_avg,
   input  logic             frame_start,
   input  logic             line_start,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [CH_W-1:0]  in_c0,
   input  logic [CH_W-1:0]  in_c1,
   input  logic [CH_W-1:0]  in_c2,
   input  logic [RAW_W-1:0] in_raw,
   output logic [7:0]       out_byte,
   output logic             out_valid
);

   generate
      if (CH_W != 8) begin : g_bad_ch
         $error("cam_byte_formatter: CH_W must be 8");
      end
      if (RAW_W < 9 || RAW_W > 16) begin : g_bad_raw
         $error("cam_byte_formatter: RAW_W must lie in 9..16");
      end
   endgenerate

   cbf_cfg_t   cfg_in;
   cbf_cfg_t   cfg_act;
   logic       accept;
   logic       busy;
   logic [7:0] chroma;
   logic [7:0] byte0;
   logic [7:0] byte1;

   assign cfg_in = '{raw_bypass: cfg_raw_bypass,
                     rgb_en:     cfg_rgb_en,
                     rgb_fmt:    rgb_fmt_e'(cfg_rgb_fmt),
                     swap_pos:   cfg_swap_pos,
                     swap_chan:  cfg_swap_chan,
                     shift3:     cfg_shift3,
                     chroma_avg: cfg_chroma_avg};

   assign in_ready = ~busy;
   assign accept   = in_valid & ~busy;

   cbf_cfg_hold u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (frame_start),
      .cfg_d (cfg_in),
      .cfg_q (cfg_act)
   );

   cbf_chroma_track #(.CH_W(CH_W), .AVG_ROUND(AVG_ROUND)) u_chroma (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (frame_start | line_start),
      .accept    (accept),
      .swap_chan (cfg_act.swap_chan),
      .avg_en    (cfg_act.chroma_avg),
      .cb        (in_c1),
      .cr        (in_c2),
      .chroma    (chroma)
   );

   cbf_word_build #(.RAW_W(RAW_W)) u_build (
      .cfg    (cfg_act),
      .c0     (in_c0),
      .c1     (in_c1),
      .c2     (in_c2),
      .chroma (chroma),
      .raw    (in_raw),
      .byte0  (byte0),
      .byte1  (byte1)
   );

   cbf_byte_ser u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .b0        (byte0),
      .b1        (byte1),
      .out_byte  (out_byte),
      .out_valid (out_valid),
      .busy      (busy)
   );

endmodule

// File: rtl/cam_byte_formatter_checker.sv
module cam_byte_formatter_checker
   import cbf_pkg::*;
#(
   parameter int RAW_W = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_start,
   input logic       line_start,
   input logic       in_valid,
   input logic       in_ready,
   input logic [7:0] out_byte,
   input logic       out_valid,
   input cbf_cfg_t   cfg_in,
   input cbf_cfg_t   cfg_act
);

   logic first_b;
   logic second_b;
   assign first_b  = out_valid & ~in_ready;
   assign second_b = out_valid & in_ready;

   AST_ACCEPT_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && !in_ready)); // R1
   AST_SECOND_BYTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      first_b |=> second_b); // R1
   AST_IDLE_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready); // R1
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(cfg_act)); // R9
   AST_CFG_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (cfg_act == $past(cfg_in))); // R9
   AST_SYNC_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start || line_start) |-> !in_valid); // R9
   AST_RAW_LOW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (second_b && cfg_act.raw_bypass) |-> (({8'd0, out_byte} >> (RAW_W - 8)) == 16'd0)); // R8
   AST_HI_PAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (first_b && !cfg_act.raw_bypass && cfg_act.rgb_en && !cfg_act.swap_pos &&
       cfg_act.rgb_fmt == RGB_444_HI_PAD) |-> (out_byte[7:4] == 4'h0)); // R4
   AST_555_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (first_b && !cfg_act.raw_bypass && cfg_act.rgb_en && !cfg_act.swap_pos &&
       cfg_act.rgb_fmt == RGB_555) |-> !out_byte[7]); // R4
   AST_LO_PAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (second_b && !cfg_act.raw_bypass && cfg_act.rgb_en && !cfg_act.swap_pos &&
       cfg_act.rgb_fmt == RGB_444_LO_PAD) |-> (out_byte[3:0] == 4'h0)); // R4

endmodule

bind cam_byte_formatter cam_byte_formatter_checker #(.RAW_W(RAW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .line_start  (line_start),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_byte    (out_byte),
   .out_valid   (out_valid),
   .cfg_in      (cfg_in),
   .cfg_act     (cfg_act)
);

// File: tb/cam_byte_formatter_bench.sv
`timescale 1ns/1ps
module cam_byte_formatter_bench;

   localparam int RAW_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_raw_bypass = 0, cfg_rgb_en = 0, cfg_swap_pos = 0;
   logic cfg_swap_chan = 0, cfg_shift3 = 0, cfg_chroma_avg = 0;
   logic [1:0] cfg_rgb_fmt = 2'b00;
   logic frame_start = 0, line_start = 0, in_valid = 0;
   logic [7:0] in_c0 = 0, in_c1 = 0, in_c2 = 0;
   logic [RAW_W-1:0] in_raw = '0;
   logic in_ready;
   logic [7:0] out_byte;
   logic out_valid;

   always #2 clk = ~clk;

   cam_byte_formatter #(.RAW_W(RAW_W)) u_cam_byte_formatter (
      .clk(clk), .rst_n(rst_n),
      .cfg_raw_bypass(cfg_raw_bypass), .cfg_rgb_en(cfg_rgb_en), .cfg_rgb_fmt(cfg_rgb_fmt),
      .cfg_swap_pos(cfg_swap_pos), .cfg_swap_chan(cfg_swap_chan), .cfg_shift3(cfg_shift3),
      .cfg_chroma_avg(cfg_chroma_avg), .frame_start(frame_start), .line_start(line_start),
      .in_valid(in_valid), .in_ready(in_ready), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
      .in_raw(in_raw), .out_byte(out_byte), .out_valid(out_valid)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   // model of the active configuration and line state
   logic       m_raw, m_rgb, m_spos, m_schan, m_sh, m_avg;
   logic [1:0] m_fmt;
   logic       m_odd, m_prev_ok;
   logic [7:0] m_pcb, m_pcr;

   function automatic logic [7:0] sh3(input logic [7:0] v);
      return {v[4:0], 3'b000};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pop one expected byte per strobed output byte
   always @(negedge clk) begin
      if (rst_n && out_valid && !done) begin
         if (exp_q.size() == 0) begin
            check(0, "R1 unexpected byte", out_byte, 0);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(out_byte == e, t, out_byte, e);
         end
      end
   end

   task automatic start_frame(input logic raw, rgb, input logic [1:0] fmt,
                              input logic spos, schan, sh, avg);
      cfg_raw_bypass = raw; cfg_rgb_en = rgb; cfg_rgb_fmt = fmt;
      cfg_swap_pos = spos; cfg_swap_chan = schan; cfg_shift3 = sh; cfg_chroma_avg = avg;
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
      m_raw = raw; m_rgb = rgb; m_fmt = fmt; m_spos = spos;
      m_schan = schan; m_sh = sh; m_avg = avg;
      m_odd = 0; m_prev_ok = 0;
   endtask

   task automatic start_line();
      line_start = 1;
      @(negedge clk);
      line_start = 0;
      m_odd = 0; m_prev_ok = 0;
   endtask

   task automatic send(input logic [7:0] a, b, c, input logic [RAW_W-1:0] raw,
                       input string tag);
      logic [7:0] e0, e1, r, g, bl, y, ch, pc;
      logic [15:0] w;
      logic [8:0] s;
      if (m_raw) begin
         e0 = raw[9:2];
         e1 = {6'b0, raw[1:0]};
      end else begin
         if (m_rgb) begin
            r = m_schan ? c : a; bl = m_schan ? a : c; g = b;
            if (m_sh) begin r = sh3(r); g = sh3(g); bl = sh3(bl); end
            case (m_fmt)
               2'b00: w = {r[7:3], g[7:2], bl[7:3]};
               2'b01: w = {1'b0, r[7:3], g[7:3], bl[7:3]};
               2'b10: w = {r[7:4], g[7:4], bl[7:4], 4'h0};
               default: w = {4'h0, r[7:4], g[7:4], bl[7:4]};
            endcase
         end else begin
            y  = a;
            ch = (m_odd ^ m_schan) ? c : b;
            pc = (m_odd ^ m_schan) ? m_pcr : m_pcb;
            if (m_avg && m_prev_ok) begin
               s = {1'b0, ch} + {1'b0, pc};
               ch = s[8:1];
            end
            if (m_sh) begin y = sh3(y); ch = sh3(ch); end
            w = {ch, y};
         end
         if (m_spos) w = {w[7:0], w[15:8]};
         e0 = w[15:8];
         e1 = w[7:0];
      end
      exp_q.push_back(e0); tag_q.push_back(tag);
      exp_q.push_back(e1); tag_q.push_back(tag);
      in_c0 = a; in_c1 = b; in_c2 = c; in_raw = raw; in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      check(in_ready == 1'b0, "R1 ready low after accept", in_ready, 0);
      @(negedge clk);
      check(in_ready == 1'b1, "R1 ready back high", in_ready, 1);
      m_odd = ~m_odd; m_prev_ok = 1; m_pcb = b; m_pcr = c;
   endtask

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_raw = 0; m_rgb = 0; m_fmt = 0; m_spos = 0; m_schan = 0; m_sh = 0; m_avg = 0;
      m_odd = 0; m_prev_ok = 0; m_pcb = 0; m_pcr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      check(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
      check(in_ready == 1, "R10 in_ready after reset", in_ready, 1);

      // R10/R2: default config is YCbCr, chroma first
      send(8'h10, 8'h20, 8'h30, '0, "R10 default ycbcr");
      send(8'h11, 8'h21, 8'h31, '0, "R2 odd pixel Cr");

      // R2: YCbCr order, parity across pixels and line start
      start_frame(0, 0, 2'b00, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++)
         send(8'h40 + 8'(i), 8'h80 + 8'(i), 8'hC0 + 8'(i), '0, "R2 ycbcr cb/cr order");
      start_line();
      send(8'h55, 8'h66, 8'h77, '0, "R2 parity restarts at line start");
      send(8'h56, 8'h67, 8'h78, '0, "R2 odd after line start");
      start_frame(0, 0, 2'b00, 1, 0, 0, 0);
      send(8'hA1, 8'hB2, 8'hC3, '0, "R2 luma first swap");
      send(8'hA4, 8'hB5, 8'hC6, '0, "R2 luma first swap odd");

      // R3: Cb/Cr exchange
      start_frame(0, 0, 2'b00, 0, 1, 0, 0);
      send(8'h01, 8'h02, 8'h03, '0, "R3 even pixel Cr");
      send(8'h04, 8'h05, 8'h06, '0, "R3 odd pixel Cb");

      // R7: chroma average
      start_frame(0, 0, 2'b00, 0, 0, 0, 1);
      send(8'h10, 8'h10, 8'hF0, '0, "R7 first pixel own chroma");
      send(8'h20, 8'h33, 8'h81, '0, "R7 avg cr");
      send(8'h30, 8'hFF, 8'h00, '0, "R7 avg cb");
      send(8'h40, 8'h01, 8'hFF, '0, "R7 avg odd sum");

      // R6: shift in YCbCr and RGB
      start_frame(0, 0, 2'b00, 0, 0, 1, 0);
      send(8'hFF, 8'h3F, 8'h25, '0, "R6 ycbcr shift");
      start_frame(0, 1, 2'b00, 0, 0, 1, 0);
      send(8'h1F, 8'h3F, 8'h13, '0, "R6 rgb565 shift");

      // R4: all four RGB layouts
      start_frame(0, 1, 2'b00, 0, 0, 0, 0);
      send(8'hF8, 8'h04, 8'h1F, '0, "R4 rgb565");
      send(8'h9C, 8'hE3, 8'h5A, '0, "R4 rgb565 mixed");
      start_frame(0, 1, 2'b01, 0, 0, 0, 0);
      send(8'hFF, 8'hFF, 8'hFF, '0, "R4 rgb555 top bit zero");
      start_frame(0, 1, 2'b10, 0, 0, 0, 0);
      send(8'hAB, 8'hCD, 8'hEF, '0, "R4 rgb444 low pad");
      start_frame(0, 1, 2'b11, 0, 0, 0, 0);
      send(8'hAB, 8'hCD, 8'hEF, '0, "R4 rgb444 high pad");

      // R5: RGB swaps
      start_frame(0, 1, 2'b00, 1, 0, 0, 0);
      send(8'hF8, 8'h04, 8'h1F, '0, "R5 rgb byte swap");
      start_frame(0, 1, 2'b00, 0, 1, 0, 0);
      send(8'hF8, 8'h04, 8'h1F, '0, "R5 rgb R/B swap");

      // R8: raw bypass overrides every other setting
      start_frame(1, 1, 2'b11, 1, 1, 1, 1);
      send(8'h12, 8'h34, 8'h56, 10'h3FF, "R8 raw all ones");
      send(8'h12, 8'h34, 8'h56, 10'h2B6, "R8 raw split");
      start_frame(1, 0, 2'b00, 0, 0, 0, 0);
      send(8'h00, 8'h00, 8'h00, 10'h001, "R8 raw low bits");

      // R9: pins changed mid-frame have no effect until frame start
      start_frame(0, 0, 2'b00, 0, 0, 0, 0);
      cfg_rgb_en = 1; cfg_swap_pos = 1; cfg_raw_bypass = 1;
      send(8'h99, 8'h88, 8'h77, 10'h155, "R9 change ignored mid-frame");
      start_line();
      send(8'h9A, 8'h8B, 8'h7C, 10'h155, "R9 still ignored after line start");
      start_frame(0, 1, 2'b00, 1, 0, 0, 0);
      send(8'h99, 8'h88, 8'h77, 10'h155, "R9 applied at frame start");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R1 all expected bytes seen", exp_q.size(), 0);
      check(out_valid == 0, "R1 strobe idle at end", out_valid, 0);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule